// File: doc/BRIEF.md
# Single-Cycle Dual-Stack Controller Processor

This block is a small stack-machine processor meant to sit next to hand-built FPGA logic and behave as predictably as that logic. Every instruction, including taken branches, calls, returns, memory reads and interrupt entry, completes in one clock. It does this by keeping the current instruction in a register and fetching the real successor in the same cycle the current one executes. Because the fetched word is never a guess, nothing is flushed and no delay slot exists.

Two stacks carry the state. The data stack feeds an adder that doubles as the operand selector and a one-bit shifter through carry. The return stack holds return addresses and also acts as the address unit: its top can be decremented and tested for zero, and it drives instruction fetch directly on a return. Each stack keeps its top in a register and the rest in a small RAM. That RAM is written on the rising edge and read on the falling edge, so a push or pop and the read of the new second entry fit inside one cycle. Program and data memories are internal and separate, but both sit in one address space. The program memory is loaded through a write port while the processor is held in reset.

Top module: `scpu_core`

## Requirements
- R1: While rst_n is low, pc_o is all ones, dtop_o and rtop_o are zero and flags_o is zero. The first clock edge after release executes a no-op and leaves pc_o at 0. Each later edge executes the instruction at pc_o.
- R2: An instruction word is {opcode[15:8], operand[7:0]}. Exactly one instruction completes per clock and a non-branch advances pc_o by one. The opcodes are NOP 0x00, LIT 0x01 (push the zero-extended operand), DUP 0x07 and DROP 0x06.
- R3: TOR 0x20 moves the data top onto the return stack. RDEC 0x22 decrements the return top and sets Z exactly when the result is zero. A three-pass loop of RDEC and BNZ, started from reset, reaches the instruction after the loop on edge 9.
- R4: JMP 0x10 jumps to the absolute address in its operand. BRA 0x11, BZ 0x12 (taken if Z), BNZ 0x13 (taken if not Z) and BC 0x14 (taken if C) branch relative to their own address by the signed operand. A taken target executes on the very next edge, and a branch that is not taken continues at its address plus one.
- R5: ADD 0x02 pops the data stack, leaves second+top as the new top, sets C to the carry out of bit 15 and sets Z when the sum is zero. flags_o is {ie[2], C[1], Z[0]}.
- R6: SHRC 0x03 shifts the data top right by one bit, moving C into bit 15 and bit 0 into C, and sets Z when the result is zero.
- R7: FETCH 0x04 replaces the top with the word at that address. STORE 0x05 writes the second entry to the address on top, then drops the address. An address with bit 8 clear selects program memory and one with bit 8 set selects data memory.
- R8: CALL 0x15 pushes its own address plus one onto the return stack and jumps to its absolute operand. RET 0x16 jumps to the return top and pops it. Each takes one edge.
- R9: When irq is high and ie is set, the edge does not execute the current instruction. In one edge it pushes that instruction's address onto the return stack and the status word {ie,C,Z} (bits 2:0) onto the data stack, clears ie and continues at address 0xF0.
- R10: EI 0x30 sets ie. RETI 0x17 pops the return top into the program counter and pops the data top into {ie,C,Z} in one edge. The interrupted instruction then runs as if never disturbed.
- R11: An interrupt is never taken on an edge that executes CALL, RET or RETI; it waits for the next boundary. While ie is clear, irq has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge, stack RAM is read on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 8 | Program memory write address |
| prog_wdata | input | 16 | Program memory write data |
| irq | input | 1 | Level interrupt request |
| pc_o | output | 8 | Address of the instruction executed on the next edge |
| dtop_o | output | 16 | Top of the data stack |
| rtop_o | output | 16 | Top of the return stack |
| flags_o | output | 3 | {ie, carry, zero} |

## Verification
Every result appears on the ports one rising edge after the instruction or interrupt that causes it. Edge 1 after reset release is the no-op, so the instruction at address k of a straight-line program lands on edge k+2. The bench releases reset on a falling edge, counts rising edges from there, and reads the outputs on the falling edge that follows the edge it has computed for each result. Interrupt entry is checked on the edge where irq is first seen, and the return on the edge that executes RETI, so the round trip is counted to the cycle. Deferral is checked edge by edge across a CALL and a RET.

// File: rtl/scpu_pkg.sv
`timescale 1ns/1ps
package scpu_pkg;
    typedef enum logic [7:0] {
        OP_NOP   = 8'h00,
        OP_LIT   = 8'h01,
        OP_ADD   = 8'h02,
        OP_SHRC  = 8'h03,
        OP_FETCH = 8'h04,
        OP_STORE = 8'h05,
        OP_DROP  = 8'h06,
        OP_DUP   = 8'h07,
        OP_JMP   = 8'h10,
        OP_BRA   = 8'h11,
        OP_BZ    = 8'h12,
        OP_BNZ   = 8'h13,
        OP_BC    = 8'h14,
        OP_CALL  = 8'h15,
        OP_RET   = 8'h16,
        OP_RETI  = 8'h17,
        OP_TOR   = 8'h20,
        OP_RDEC  = 8'h22,
        OP_EI    = 8'h30
    } op_e;
endpackage

// File: rtl/scpu_stack.sv
`timescale 1ns/1ps
// Stack body below a register-held top. Written on the rising edge,
// read on the falling edge so the new second entry is ready mid-cycle.
module scpu_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] spill,
    output logic [W-1:0] nos
);
    localparam int SPW = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [SPW-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (push)     sp_d = sp_q + 1'b1;
        else if (pop) sp_d = sp_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[sp_q + 1'b1] <= spill;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) nos <= '0;
        else        nos <= mem[sp_q];
    end

    AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)) else $error("stack push and pop together"); // R2
endmodule

// File: rtl/scpu_alu.sv
`timescale 1ns/1ps
// Adder that also selects: gating an operand to zero passes the other.
module scpu_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_a,
    input  logic         use_b,
    output logic [W-1:0] sum,
    output logic         co
);
    always_comb begin
        {co, sum} = {1'b0, a & {W{use_a}}} + {1'b0, b & {W{use_b}}};
    end
endmodule

// File: rtl/scpu_core.sv
`timescale 1ns/1ps
module scpu_core
    import scpu_pkg::*;
#(
    parameter int          DW     = 16,
    parameter int          PAW    = 8,
    parameter int          DAW    = 8,
    parameter int          SDEPTH = 16,
    parameter int unsigned IVEC   = 240
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_we,
    input  logic [PAW-1:0] prog_addr,
    input  logic [DW-1:0]  prog_wdata,
    input  logic           irq,
    output logic [PAW-1:0] pc_o,
    output logic [DW-1:0]  dtop_o,
    output logic [DW-1:0]  rtop_o,
    output logic [2:0]     flags_o
);
    localparam int RB     = (PAW > DAW) ? PAW : DAW;
    localparam int PDEPTH = 1 << PAW;
    localparam int DDEPTH = 1 << DAW;
    localparam logic [PAW-1:0] IVEC_A = PAW'(IVEC);

    typedef struct packed {
        logic [PAW-1:0] pc;
        logic [DW-1:0]  ir;
        logic [DW-1:0]  t;
        logic [DW-1:0]  r;
        logic           c;
        logic           z;
        logic           ie;
    } core_s;

    core_s s_d, s_q;

    logic [DW-1:0]  pmem [PDEPTH];
    logic [DW-1:0]  dmem [DDEPTH];

    op_e            op;
    logic [7:0]     imm;
    logic [PAW-1:0] pc_inc, rel_tgt, abs_tgt, pc_next;
    logic [DW-1:0]  d_nos, r_nos, rdata, r_dec, alu_sum;
    logic           d_push, d_pop, r_push, r_pop, st_we, irq_take;
    logic           alu_ua, alu_ub, alu_co;

    assign op      = op_e'(s_q.ir[15:8]);
    assign imm     = s_q.ir[7:0];
    assign pc_inc  = s_q.pc + 1'b1;
    assign rel_tgt = s_q.pc + PAW'($signed(imm));
    assign abs_tgt = PAW'(imm);
    assign r_dec   = s_q.r - 1'b1;
    assign rdata   = s_q.t[RB] ? dmem[s_q.t[DAW-1:0]] : pmem[s_q.t[PAW-1:0]];

    scpu_stack #(.W(DW), .DEPTH(SDEPTH)) dstk_i (
        .clk(clk), .rst_n(rst_n), .push(d_push), .pop(d_pop),
        .spill(s_q.t), .nos(d_nos));

    scpu_stack #(.W(DW), .DEPTH(SDEPTH)) rstk_i (
        .clk(clk), .rst_n(rst_n), .push(r_push), .pop(r_pop),
        .spill(s_q.r), .nos(r_nos));

    scpu_alu #(.W(DW)) alu_i (
        .a(d_nos), .b(s_q.t), .use_a(alu_ua), .use_b(alu_ub),
        .sum(alu_sum), .co(alu_co));

    always_comb begin
        s_d      = s_q;
        d_push   = 1'b0;
        d_pop    = 1'b0;
        r_push   = 1'b0;
        r_pop    = 1'b0;
        st_we    = 1'b0;
        alu_ua   = 1'b0;
        alu_ub   = 1'b1;
        pc_next  = pc_inc;
        irq_take = irq && s_q.ie && !(op == OP_CALL || op == OP_RET || op == OP_RETI);
        if (irq_take) begin
            d_push  = 1'b1;
            s_d.t   = DW'({s_q.ie, s_q.c, s_q.z});
            r_push  = 1'b1;
            s_d.r   = DW'(s_q.pc);
            s_d.ie  = 1'b0;
            pc_next = IVEC_A;
        end else begin
            case (op)
                OP_LIT: begin
                    d_push = 1'b1;
                    s_d.t  = DW'(imm);
                end
                OP_ADD: begin
                    alu_ua = 1'b1;
                    d_pop  = 1'b1;
                    s_d.t  = alu_sum;
                    s_d.c  = alu_co;
                    s_d.z  = (alu_sum == '0);
                end
                OP_SHRC: begin
                    s_d.t = {s_q.c, s_q.t[DW-1:1]};
                    s_d.c = s_q.t[0];
                    s_d.z = ({s_q.c, s_q.t[DW-1:1]} == '0);
                end
                OP_FETCH: s_d.t = rdata;
                OP_STORE, OP_DROP: begin
                    st_we  = (op == OP_STORE);
                    d_pop  = 1'b1;
                    alu_ua = 1'b1;
                    alu_ub = 1'b0;
                    s_d.t  = alu_sum;
                end
                OP_DUP: d_push = 1'b1;
                OP_JMP: pc_next = abs_tgt;
                OP_BRA: pc_next = rel_tgt;
                OP_BZ:  if (s_q.z)  pc_next = rel_tgt;
                OP_BNZ: if (!s_q.z) pc_next = rel_tgt;
                OP_BC:  if (s_q.c)  pc_next = rel_tgt;
                OP_CALL: begin
                    r_push  = 1'b1;
                    s_d.r   = DW'(pc_inc);
                    pc_next = abs_tgt;
                end
                OP_RET, OP_RETI: begin
                    r_pop   = 1'b1;
                    s_d.r   = r_nos;
                    pc_next = s_q.r[PAW-1:0];
                    if (op == OP_RETI) begin
                        d_pop = 1'b1;
                        s_d.t = d_nos;
                        {s_d.ie, s_d.c, s_d.z} = s_q.t[2:0];
                    end
                end
                OP_TOR: begin
                    r_push = 1'b1;
                    s_d.r  = s_q.t;
                    d_pop  = 1'b1;
                    s_d.t  = d_nos;
                end
                OP_RDEC: begin
                    s_d.r = r_dec;
                    s_d.z = (r_dec == '0);
                end
                OP_EI:   s_d.ie = 1'b1;
                default: ;
            endcase
        end
        s_d.pc = pc_next;
        s_d.ir = pmem[pc_next];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.pc <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (prog_we)                  pmem[prog_addr] <= prog_wdata;
        else if (st_we && !s_q.t[RB]) pmem[s_q.t[PAW-1:0]] <= d_nos;
        if (st_we && s_q.t[RB])       dmem[s_q.t[DAW-1:0]] <= d_nos;
    end

    assign pc_o    = s_q.pc;
    assign dtop_o  = s_q.t;
    assign rtop_o  = s_q.r;
    assign flags_o = {s_q.ie, s_q.c, s_q.z};

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && (op == OP_NOP || op == OP_LIT || op == OP_DUP || op == OP_ADD))
        |=> (s_q.pc == $past(s_q.pc) + 1'b1)) else $error("sequential step"); // R2
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && op == OP_ADD)
        |=> ({s_q.c, s_q.t} == ({1'b0, $past(d_nos)} + {1'b0, $past(s_q.t)}))) else $error("add"); // R5
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> (s_q.r == DW'($past(s_q.pc) + 1'b1))) else $error("call link"); // R8
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (s_q.pc == IVEC_A && !s_q.ie && s_q.r == DW'($past(s_q.pc)))) else $error("irq entry"); // R9
    AST_RETI_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETI) |=> (s_q.ie == $past(s_q.t[2]))) else $error("reti ie"); // R10
    AST_CALL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && op == OP_CALL) |=> (s_q.pc == PAW'($past(imm)))) else $error("irq during call"); // R11
endmodule

// File: tb/scpu_core_tb_top.sv
`timescale 1ns/1ps
module scpu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic        irq = 1'b0;
    logic [7:0]  pc_o;
    logic [15:0] dtop_o, rtop_o;
    logic [2:0]  flags_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    scpu_core dut_i (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .irq(irq), .pc_o(pc_o), .dtop_o(dtop_o),
        .rtop_o(rtop_o), .flags_o(flags_o));

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int word);
        prog_addr  = addr[7:0];
        prog_wdata = word[15:0];
        prog_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prog_we    = 1'b0;
    endtask

    task automatic ins(input int addr, input int opc, input int arg);
        wr(addr, (opc << 8) | (arg & 8'hFF));
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        irq   = 1'b0;
        for (int i = 0; i < 256; i++) wr(i, 0);
    endtask

    task automatic go();
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_loop();
        boot();
        ins(0, 8'h01, 3); ins(1, 8'h20, 0); ins(2, 8'h22, 0);
        ins(3, 8'h13, 8'hFF); ins(4, 8'h10, 4);
        chk("R1", "reset pc", pc_o, 8'hFF);
        chk("R1", "reset dtop", dtop_o, 0);
        chk("R1", "reset rtop", rtop_o, 0);
        chk("R1", "reset flags", flags_o, 0);
        go();
        step(1); chk("R1", "first fetch pc", pc_o, 0);
        step(1); chk("R2", "lit top", dtop_o, 3);
        chk("R2", "lit advances pc", pc_o, 1);
        step(1); chk("R3", "tor rtop", rtop_o, 3);
        step(5); chk("R3", "loop still running edge 8", pc_o, 3);
        chk("R3", "counter zero", rtop_o, 0);
        chk("R3", "zero flag", flags_o, 1);
        step(1); chk("R3", "loop exit edge 9", pc_o, 4);
    endtask

    task automatic t_branch();
        boot();
        ins(0, 8'h01, 8'h80); ins(1, 8'h04, 0); ins(2, 8'h01, 1); ins(3, 8'h02, 0);
        ins(4, 8'h14, 3); ins(5, 8'h01, 8'h55); ins(6, 8'h10, 6); ins(7, 8'h03, 0);
        ins(8, 8'h12, 8'hFE); ins(9, 8'h11, 0); wr(8'h80, 16'hFFFF);
        go();
        step(3); chk("R7", "fetch program region", dtop_o, 16'hFFFF);
        step(2); chk("R5", "add wraps", dtop_o, 0);
        chk("R5", "add carry and zero", flags_o, 3);
        step(1); chk("R4", "bc taken relative", pc_o, 7);
        step(1); chk("R6", "shrc result", dtop_o, 16'h8000);
        chk("R6", "shrc flags", flags_o, 0);
        step(1); chk("R4", "bz not taken", pc_o, 9);
        step(1); chk("R4", "bra self", pc_o, 9);
        chk("R4", "skipped lit", dtop_o, 16'h8000);
    endtask

    task automatic t_call();
        boot();
        ins(0, 8'h01, 8'h42); ins(1, 8'h15, 8'h20); ins(2, 8'h01, 8'h81);
        ins(3, 8'h04, 0); ins(4, 8'h04, 0); ins(5, 8'h10, 5);
        ins(8'h20, 8'h07, 0); ins(8'h21, 8'h02, 0); ins(8'h22, 8'h01, 8'h81);
        ins(8'h23, 8'h04, 0); ins(8'h24, 8'h05, 0); ins(8'h25, 8'h16, 0);
        wr(8'h81, 16'h0105);
        go();
        step(3); chk("R8", "call target", pc_o, 8'h20);
        chk("R8", "call link", rtop_o, 2);
        step(2); chk("R5", "add no carry", dtop_o, 16'h84);
        chk("R5", "add flags clear", flags_o, 0);
        step(3); chk("R7", "store keeps data", dtop_o, 16'h84);
        step(1); chk("R8", "ret target", pc_o, 2);
        chk("R8", "ret pops", rtop_o, 0);
        step(3); chk("R7", "data region readback", dtop_o, 16'h84);
        chk("R7", "pc after readback", pc_o, 5);
    endtask

    task automatic t_irq();
        boot();
        ins(0, 8'h30, 0); ins(1, 8'h01, 7); ins(2, 8'h01, 9); ins(3, 8'h02, 0);
        ins(4, 8'h10, 4); ins(8'hF0, 8'h01, 8'h80); ins(8'hF1, 8'h04, 0);
        ins(8'hF2, 8'h01, 1); ins(8'hF3, 8'h02, 0); ins(8'hF4, 8'h06, 0);
        ins(8'hF5, 8'h17, 0); wr(8'h80, 16'hFFFF);
        go();
        step(2); chk("R10", "ei sets ie", flags_o, 4);
        step(1); irq = 1'b1;
        step(1); irq = 1'b0;
        chk("R9", "vector", pc_o, 8'hF0);
        chk("R9", "status pushed", dtop_o, 4);
        chk("R9", "return address", rtop_o, 2);
        chk("R9", "ie cleared", flags_o, 0);
        step(4); chk("R9", "isr flags", flags_o, 3);
        step(2); chk("R10", "reti pc", pc_o, 2);
        chk("R10", "reti data top", dtop_o, 7);
        chk("R10", "reti rtop", rtop_o, 0);
        chk("R10", "reti flags", flags_o, 4);
        step(2); chk("R10", "resumed sum", dtop_o, 16'h10);
        chk("R10", "resumed pc", pc_o, 4);
    endtask

    task automatic t_defer();
        boot();
        ins(0, 8'h30, 0); ins(1, 8'h15, 8'h10); ins(2, 8'h10, 2);
        ins(8'h10, 8'h16, 0); ins(8'hF0, 8'h17, 0);
        go();
        step(2); irq = 1'b1;
        step(1); chk("R11", "held over call", pc_o, 8'h10);
        chk("R11", "call link", rtop_o, 2);
        step(1); chk("R11", "held over ret", pc_o, 2);
        step(1); irq = 1'b0;
        chk("R11", "taken at boundary", pc_o, 8'hF0);
        chk("R11", "deferred return address", rtop_o, 2);
        step(1); chk("R11", "back after reti", pc_o, 2);
        chk("R11", "ie restored", flags_o, 4);
        boot();
        ins(0, 8'h00, 0); ins(1, 8'h10, 1);
        irq = 1'b1;
        go();
        step(4); chk("R11", "masked pc", pc_o, 1);
        chk("R11", "masked rtop", rtop_o, 0);
        chk("R11", "masked flags", flags_o, 0);
        irq = 1'b0;
    endtask

    initial begin
        t_loop();
        t_branch();
        t_call();
        t_irq();
        t_defer();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule